// File: doc/BRIEF.md
# Third-Order Multi-Level Noise-Shaping Modulator

This block is the digital noise shaper that sits between an interpolation chain and a unit-element current-steering converter. Each enabled clock it takes one signed high-resolution sample at the oversampled rate. It runs the sample through three cascaded integrators whose outputs are summed forward into a 5-bit quantizer. It returns a code from 0 to 31, and the code says how many unit current cells to switch on. The noise transfer function is (1 - z^-1)^3, so the quantization error is pushed out of the low-frequency signal band.

A pseudo-random dither of less than one quantizer step can be added in front of the quantizer to break up idle tones. Every integrator saturates at its range limits, so a full-scale input can never make an accumulator wrap and flip the output. The loop has the same rate and latency whichever oversampling ratio the surrounding clocking selects. A synchronous reset and a clock enable control the whole state.

Top module: `sdm3_ff_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `code` to the mid-scale value 16, clears all three integrators to 0 and loads the dither register with the value 1.
- R2: While `en` is low, `code`, the integrators and the dither register all hold. After `en` returns high, the output sequence continues exactly as if the paused cycles had not happened.
- R3: The quantizer step is 2^19, that is 2^(24-5), in input units. The code is clamp(floor((y + 2^18) / 2^19) + 16, 0, 31), so it saturates at 0 and 31.
- R4: The quantizer input is y = x + 3*i1 + 3*i2 + i3 + d, where x is the current `x_in` as a signed 24-bit value and d is the dither term.
- R5: With v = (code_new - 16) * 2^19, each enabled cycle computes i1 <= sat(i1 + x - v), i2 <= sat(i2 + i1) and i3 <= sat(i3 + i2), using the old integrator values on the right-hand side. The sat function clamps to the signed 30-bit range [-2^29, 2^29 - 1].
- R6: The dither register is a 23-bit shift register. On every enabled cycle it advances as s <= {s[21:0], s[22] ^ s[17]}, whether or not dither is used. When `dith_en` is high, d is bits [18:0] of s read as a signed 19-bit value. When `dith_en` is low, d is 0.
- R7: `code` is registered. It changes at the rising edge that samples the `x_in` it depends on, so the result is visible one cycle after the input is applied.
- R8: For a constant input within the stable range, the mean of (code - 16) * 2^19 over 2048 cycles is within 2^16 of the input.
- R9: A constant positive full-scale input (2^23 - 1) holds `code` at 31 on every cycle, and it never wraps to a low code. A constant negative full-scale input (-2^23) holds `code` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for all state |
| dith_en | input | 1 | Adds the pseudo-random dither when high |
| x_in | input | 24 | Signed input sample |
| code | output | 5 | Unsigned quantizer code, 16 is mid-scale |

## Verification
Each code is due exactly one edge after its input. The bench drives `x_in`, `en` and `dith_en` on the falling edge and steps its own model of the loop equations for that cycle. It then samples `code` one nanosecond after the next rising edge. Hold checks during pauses, the saturated full-scale runs and the running mean are read at the same point in the cycle, so a result is never compared against an input the design has not yet sampled.

// File: rtl/sdm3_ff_mod.sv
module sdm3_ff_mod #(
  parameter int IN_W   = 24,
  parameter int CODE_W = 5,
  parameter int GUARD  = 6,
  parameter int LFSR_W = 23,
  parameter int TAP    = 18
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   dith_en,
  input  logic signed [IN_W-1:0] x_in,
  output logic [CODE_W-1:0]      code
);

  localparam int W    = IN_W + GUARD;
  localparam int SW   = W + 4;
  localparam int QS   = IN_W - CODE_W;
  localparam int MID  = 1 << (CODE_W - 1);
  localparam int TOPC = (1 << CODE_W) - 1;
  localparam logic signed [SW-1:0]  HALF = SW'(1) <<< (QS - 1);
  localparam logic signed [W+1:0]   IMAX = (W+2)'(1) <<< (W - 1);
  localparam logic signed [W+1:0]   HI   = IMAX - (W+2)'(1);
  localparam logic signed [W+1:0]   LO   = -IMAX;
  localparam logic signed [W-1:0]   I_HI = HI[W-1:0];

  logic signed [W-1:0] i1, i2, i3;
  logic [LFSR_W-1:0]   lfsr;

  function automatic logic signed [W-1:0] sat(input logic signed [W+1:0] v);
    if (v > HI)      return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else             return v[W-1:0];
  endfunction

  wire signed [SW-1:0] xs  = x_in;
  wire signed [SW-1:0] i1x = i1;
  wire signed [SW-1:0] i2x = i2;
  wire signed [SW-1:0] i3x = i3;
  wire signed [QS-1:0] draw = lfsr[QS-1:0];
  wire signed [SW-1:0] dfull = draw;
  wire signed [SW-1:0] dx = dith_en ? dfull : '0;

  wire signed [SW-1:0] y  = xs + (i1x <<< 1) + i1x + (i2x <<< 1) + i2x + i3x + dx;
  wire signed [SW-1:0] yr = y + HALF;
  wire signed [SW-1:0] qs = yr >>> QS;
  wire signed [SW-1:0] qoff = qs + SW'(MID);

  logic [CODE_W-1:0] q_next;
  always_comb begin
    if (qs < -MID)          q_next = '0;
    else if (qs > MID - 1)  q_next = CODE_W'(TOPC);
    else                    q_next = qoff[CODE_W-1:0];
  end

  wire signed [CODE_W:0] qc  = $signed({1'b0, q_next}) - (CODE_W+1)'(MID);
  wire signed [W:0]      qcx = qc;
  wire signed [W:0]      fb  = qcx <<< QS;
  wire signed [W:0]      xe  = x_in;
  wire signed [W:0]      e   = xe - fb;

  wire signed [W+1:0] s1 = (W+2)'(i1) + (W+2)'(e);
  wire signed [W+1:0] s2 = (W+2)'(i2) + (W+2)'(i1);
  wire signed [W+1:0] s3 = (W+2)'(i3) + (W+2)'(i2);

  wire fb_bit = lfsr[LFSR_W-1] ^ lfsr[TAP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CODE_W'(MID);
      i1   <= '0;
      i2   <= '0;
      i3   <= '0;
      lfsr <= LFSR_W'(1);
    end else if (en) begin
      code <= q_next;
      i1   <= sat(s1);
      i2   <= sat(s2);
      i3   <= sat(s3);
      lfsr <= {lfsr[LFSR_W-2:0], fb_bit};
    end
  end

  AST_RESET_MID: assert property (@(posedge clk) rst |=> code == CODE_W'(MID)); // R1
  AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(code) && $stable(i3)); // R2
  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst) en |=> lfsr != '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (en && i1 == I_HI && e > 0) |=> i1 == I_HI); // R5
  AST_FULLSCALE_TOP: assert property (@(posedge clk) disable iff (rst)
    (en && x_in == {1'b0, {(IN_W-1){1'b1}}} && code == CODE_W'(TOPC) && i1 >= 0 && i2 >= 0 && i3 >= 0)
    |=> code == CODE_W'(TOPC)); // R9

endmodule

// File: tb/sdm3_ff_mod_tb.sv
module sdm3_ff_mod_tb;
  logic clk = 1'b0;
  logic rst, en, dith_en;
  logic signed [23:0] x_in;
  logic [4:0] code;

  int checks = 0, errors = 0;
  bit done = 0;

  longint m1, m2, m3;
  int mcode;
  logic [22:0] mlf;

  always #2 clk = ~clk;

  sdm3_ff_mod u_dut (.clk(clk), .rst(rst), .en(en), .dith_en(dith_en), .x_in(x_in), .code(code));

  function automatic longint sat30(longint v);
    if (v > (longint'(1) <<< 29) - 1) return (longint'(1) <<< 29) - 1;
    if (v < -(longint'(1) <<< 29)) return -(longint'(1) <<< 29);
    return v;
  endfunction

  task automatic model_reset();
    m1 = 0; m2 = 0; m3 = 0; mcode = 16; mlf = 23'd1;
  endtask

  task automatic model_step(longint x, bit e, bit d);
    longint dv, y, q, v, er, n1, n2, n3;
    if (!e) return;
    dv = d ? longint'($signed(mlf[18:0])) : 0;
    y  = x + 3*m1 + 3*m2 + m3 + dv;
    q  = ((y + 262144) >>> 19) + 16;
    if (q < 0) q = 0;
    if (q > 31) q = 31;
    v  = (q - 16) * 524288;
    er = x - v;
    n1 = sat30(m1 + er); n2 = sat30(m2 + m1); n3 = sat30(m3 + m2);
    m1 = n1; m2 = n2; m3 = n3;
    mlf = {mlf[21:0], mlf[22] ^ mlf[17]};
    mcode = int'(q);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: code=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(longint x, bit e, bit d, string req);
    @(negedge clk);
    x_in = 24'(x); en = e; dith_en = d;
    model_step(x, e, d);
    @(posedge clk); #1;
    check(req, int'(code), mcode);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 0; dith_en = 0; x_in = '0;
    @(posedge clk); #1;
    @(negedge clk); rst = 0;
    model_reset();
  endtask

  task automatic t_reset();
    @(negedge clk); x_in = 24'sd3000000; en = 1; dith_en = 1; rst = 1;
    @(posedge clk); #1;
    check("R1 reset mid-scale", int'(code), 16);
    @(negedge clk); rst = 0; en = 0;
    model_reset();
    cycle(0, 1, 0, "R1 first code after reset");
  endtask

  task automatic t_dc_nodither();
    for (int k = 0; k < 64; k++) cycle(1234567, 1, 0, "R4 R5 R7 dc input");
    for (int k = 0; k < 64; k++) cycle(-2000000, 1, 0, "R3 R5 negative dc");
  endtask

  task automatic t_ramp_dither();
    for (int k = 0; k < 400; k++) begin
      longint t = (k % 200) < 100 ? (k % 200) * 50000 - 2500000 : (200 - (k % 200)) * 50000 - 2500000;
      cycle(t, 1, 1, "R6 dithered ramp");
    end
  endtask

  task automatic t_pause();
    int held;
    for (int k = 0; k < 20; k++) cycle(777777, 1, 1, "R2 before pause");
    held = int'(code);
    for (int k = 0; k < 15; k++) begin
      cycle(-5000000, 0, k[0], "R2 paused");
      check("R2 code held", int'(code), held);
    end
    for (int k = 0; k < 40; k++) cycle(777777, 1, 1, "R2 resume continues");
  endtask

  task automatic t_fullscale();
    do_reset();
    for (int k = 0; k < 200; k++) begin
      cycle(8388607, 1, 0, "R9 positive full scale");
      check("R9 code pinned at 31", int'(code), 31);
    end
    do_reset();
    for (int k = 0; k < 100; k++) begin
      cycle(-8388608, 1, 1, "R9 negative full scale");
      check("R9 code pinned at 0", int'(code), 0);
    end
  endtask

  task automatic t_mean();
    longint acc = 0, x = 1672864, diff;
    do_reset();
    for (int k = 0; k < 2048; k++) begin
      cycle(x, 1, 1, "R8 mean run");
      acc += (longint'(code) - 16) * 524288;
    end
    diff = acc / 2048 - x;
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > 65536) begin
      errors++;
      $display("FAIL R8 mean: mean=%0d expected=%0d", acc / 2048, x);
    end
  endtask

  initial begin
    rst = 1; en = 0; dith_en = 0; x_in = '0;
    model_reset();
    repeat (3) @(posedge clk);
    t_reset();
    t_dc_nodither();
    t_ramp_dither();
    t_pause();
    t_fullscale();
    t_mean();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule